// File: doc/BRIEF.md
# Dual Down-Counting Interrupt Timer

This peripheral holds two 32-bit down counters behind one register window on a simple word-addressed bus. Each counter has its own set of six registers: the live count, a reload value, a background reload value, a control word, a latched expiry flag and a read-only masked view of that flag. It also drives its own level-sensitive interrupt line.

Software writes a reload value and then sets the enable bit. The counter loads and counts down by one each clock. When it reaches zero it latches an expiry flag. In periodic mode it then reloads and keeps running. In one-shot mode it stops at zero. The background reload path lets software change the next period without disturbing the count already in progress. The expiry flag is cleared by writing a one to it. Each interrupt line is the expiry flag gated by that timer's interrupt-enable bit.

Writes complete on the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr`.

Top module: `dual_dntimer`

## Requirements
- R1: After a synchronous active-low reset, every register of both timers reads zero, both counters are stopped and both interrupt lines are low.
- R2: Word addresses 0-5 select timer 0 and 6-11 select timer 1. Within a bank, the local offsets are 0 live count, 1 reload, 2 background reload, 3 control, 4 expiry flag and 5 masked flag. An access to one timer never changes the other timer.
- R3: Word addresses 12 and above read as zero, and writes to them change no register.
- R4: Control bit 0 is the enable bit, bit 1 selects one-shot mode and bit 2 is the interrupt enable. Only bits 2:0 are stored; the upper bits read as zero. A control write with bit 0 set loads the counter from the reload register on that same clock edge.
- R5: A running counter decrements once per clock. A clock at which it is already zero is an expiry: bit 0 of the expiry flag register is set, and in periodic mode the counter reloads, giving a period of reload+1 clocks.
- R6: In one-shot mode an expiry sets the flag and leaves the counter stopped at zero. The count does not change until it is restarted.
- R7: Writing 1 to bit 0 of the expiry flag register clears the flag, and writing 0 leaves it unchanged. If an expiry occurs in the same cycle as the clearing write, the flag stays set.
- R8: The masked flag register reads as the expiry flag ANDed with the interrupt-enable bit, in bit 0. The timer's interrupt line carries the same value.
- R9: Writing the reload register while the enable bit is set restarts the count from the new value on that edge. While the enable bit is clear, the write only stores the value.
- R10: Writing the background reload register updates both the background and reload registers and leaves the running count undisturbed. The new value is used at the next reload.
- R11: Writes to the live count and masked flag registers are ignored. Clearing the enable bit freezes the count at its present value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 2 | Level interrupt, one bit per timer |

## Verification
The counting function is exercised with a short periodic reload, a one-shot run with the interrupt masked, and a run whose next period is changed through the background register. Comparing the live count at the cycles just before and just after an expiry separates the reload+1 period from an off-by-one count. It also separates a periodic reload from a one-shot stop, and a background update from an immediate restart. Reload writes are issued with the enable bit both set and clear, which shows whether a write restarts or merely stores. Flag writes of 0 and 1, together with writes to read-only and unmapped addresses, show that only the intended state changes.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual down-counting timer.
// Assumes a fixed register layout of six words per timer bank.
package dtmr_pkg;
    localparam int unsigned REG_COUNT = 6;
    localparam int unsigned OFF_W     = 3;

    // Local register offsets inside one timer bank.
    typedef enum logic [OFF_W-1:0] {
        OFF_CUR    = 3'd0,
        OFF_LOAD   = 3'd1,
        OFF_BGLOAD = 3'd2,
        OFF_CTRL   = 3'd3,
        OFF_RAW    = 3'd4,
        OFF_MASKED = 3'd5
    } reg_off_e;

    localparam int unsigned CTRL_EN_BIT      = 0;
    localparam int unsigned CTRL_ONESHOT_BIT = 1;
    localparam int unsigned CTRL_IE_BIT      = 2;

    // Stored control bits, MSB first.
    typedef struct packed {
        logic ie;
        logic oneshot;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/dtmr_decode.sv
`timescale 1ns/1ps
// Bank decoder: splits one word address window into per-timer selects
// and a local register offset. Assumes contiguous banks of BANK_WORDS
// words starting at word 0; addresses past the last bank select nothing.
module dtmr_decode #(
    parameter int unsigned N_TIMERS   = 2,
    parameter int unsigned BANK_WORDS = 6,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned OFF_W      = 3
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [N_TIMERS-1:0] hit,
    output logic [OFF_W-1:0]    local_off
);
    // Compare the address against each bank window and subtract its base.
    always_comb begin
        int unsigned a_v;
        a_v       = int'(addr);
        hit       = '0;
        local_off = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (a_v >= i * BANK_WORDS && a_v < (i + 1) * BANK_WORDS) begin
                hit[i]    = 1'b1;
                local_off = OFF_W'(a_v - i * BANK_WORDS);
            end
        end
    end
endmodule

// File: rtl/dtmr_counter.sv
`timescale 1ns/1ps
// Counter core of one timer: loads on start, decrements each clock while
// running, and reports expiry when already at zero. Periodic mode reloads
// from reload_val; one-shot mode stops at zero. A start or stop request
// outranks expiry in the same cycle.
module dtmr_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_val,
    input  logic              stop,
    input  logic              oneshot,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count_o,
    output logic              expire_o
);
    logic [DATA_W-1:0] count_q;
    logic              run_q;

    // Expiry: running, at zero, and not overridden by a bus request.
    assign expire_o = run_q && (count_q == '0) && !start && !stop;
    assign count_o  = count_q;

    // Count state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (start) begin
            count_q <= start_val;
            run_q   <= 1'b1;
        end else if (stop) begin
            run_q   <= 1'b0;
        end else if (run_q) begin
            if (count_q == '0) begin
                if (oneshot) run_q   <= 1'b0;
                else         count_q <= reload_val;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == $past(start_val)) && run_q);
    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && count_q != '0 && !start && !stop) |=> count_q == $past(count_q) - 1'b1);
    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && oneshot) |=> !run_q && count_q == '0);
    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> $stable(count_q));
endmodule

// File: rtl/dtmr_channel.sv
`timescale 1ns/1ps
// One timer channel: register file, counter core and interrupt gating.
// Assumes wr_en is already qualified by bank select and that off is the
// local register offset (0..5). Read data is combinational.
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] bg_q;
    ctrl_t             ctrl_q;
    logic              raw_q;
    logic [DATA_W-1:0] count;
    logic              expire;
    logic              start;
    logic              stop;
    logic              wr_ctrl;
    logic              wr_load;
    logic              wr_bg;
    logic              wr_raw;

    assign wr_ctrl = wr_en && (off == OFF_CTRL);
    assign wr_load = wr_en && (off == OFF_LOAD);
    assign wr_bg   = wr_en && (off == OFF_BGLOAD);
    assign wr_raw  = wr_en && (off == OFF_RAW);

    // Start on an enabling control write or a reload write while enabled.
    assign start = (wr_ctrl && wdata[CTRL_EN_BIT]) || (wr_load && ctrl_q.en);
    assign stop  = wr_ctrl && !wdata[CTRL_EN_BIT];

    dtmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_val  (wr_load ? wdata : load_q),
        .stop       (stop),
        .oneshot    (ctrl_q.oneshot),
        .reload_val (load_q),
        .count_o    (count),
        .expire_o   (expire)
    );

    // Control, reload and background registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            bg_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[2:0]);
            if (wr_load) load_q <= wdata;
            if (wr_bg) begin
                bg_q   <= wdata;
                load_q <= wdata;
            end
        end
    end

    // Expiry flag: set on expiry (wins), cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                     raw_q <= 1'b0;
        else if (expire)                raw_q <= 1'b1;
        else if (wr_raw && wdata[0])    raw_q <= 1'b0;
    end

    assign irq = raw_q & ctrl_q.ie;

    // Register read mux.
    always_comb begin
        rdata = '0;
        case (off)
            OFF_CUR:    rdata = count;
            OFF_LOAD:   rdata = load_q;
            OFF_BGLOAD: rdata = bg_q;
            OFF_CTRL:   rdata = DATA_W'(ctrl_q);
            OFF_RAW:    rdata = DATA_W'(raw_q);
            OFF_MASKED: rdata = DATA_W'(irq);
            default:    rdata = '0;
        endcase
    end

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && wdata[0] && !expire) |=> !raw_q);
    assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && !wdata[0] && !expire) |=> $stable(raw_q));
    assert_expiry_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_q);
    assert_bg_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bg && !start && !stop && !expire && count != '0 && $past(start) == 1'b0
         && ctrl_q.en) |=> (count == $past(count) - 1'b1) || (count == $past(count)));
endmodule

// File: rtl/dual_dntimer.sv
`timescale 1ns/1ps
// Two independent down-counting interrupt timers sharing one register
// window. Assumes single-cycle writes (bus_sel & bus_we) and combinational
// reads; unmapped addresses read zero and ignore writes.
module dual_dntimer
    import dtmr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned N_TIMERS   = 2,
    parameter int unsigned BANK_WORDS = REG_COUNT,
    parameter int unsigned ADDR_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_TIMERS-1:0] irq
);
    logic [N_TIMERS-1:0] hit;
    logic [OFF_W-1:0]    local_off;
    logic [DATA_W-1:0]   ch_rdata [N_TIMERS];

    dtmr_decode #(
        .N_TIMERS   (N_TIMERS),
        .BANK_WORDS (BANK_WORDS),
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W)
    ) u_dec (
        .addr      (bus_addr),
        .hit       (hit),
        .local_off (local_off)
    );

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_ch
        dtmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_sel && bus_we && hit[g]),
            .off   (local_off),
            .wdata (bus_wdata),
            .rdata (ch_rdata[g]),
            .irq   (irq[g])
        );
    end

    // Return the selected bank's data; zero when no bank is hit.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (hit[i]) bus_rdata = ch_rdata[i];
        end
    end

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/sim_dual_dntimer.sv
`timescale 1ns/1ps
// Directed bench for dual_dntimer: one task per scenario.
module sim_dual_dntimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    dual_dntimer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock edge; returns at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Single-cycle write; costs exactly one clock edge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 5'(a); bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int a, input logic [31:0] exp);
        bus_addr = 5'(a);
        #0.1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 12; a++) rd_check("R1 reset reg", a, 32'h0);
        check("R1 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_periodic;
        wr(1, 32'd4);                 // disabled: store only
        rd_check("R9 stored while disabled", 0, 32'd0);
        wr(3, 32'h5);                 // en + ie
        rd_check("R4 load on enable", 0, 32'd4);
        step(4);
        rd_check("R5 count reaches zero", 0, 32'd0);
        rd_check("R5 no flag yet", 4, 32'd0);
        check("R8 irq low before expiry", 32'(irq[0]), 32'd0);
        step(1);
        rd_check("R5 flag set", 4, 32'd1);
        rd_check("R5 periodic reload", 0, 32'd4);
        rd_check("R8 masked view", 5, 32'd1);
        check("R8 irq high", 32'(irq[0]), 32'd1);
        check("R2 other timer quiet", 32'(irq[1]), 32'd0);
        step(1);
        rd_check("R5 keeps running", 0, 32'd3);
    endtask

    task automatic t_clear_and_ignore;
        wr(3, 32'h4);                 // disable, keep ie
        step(2);
        rd_check("R11 frozen on disable", 0, 32'd3);
        wr(0, 32'd99);
        rd_check("R11 live count write ignored", 0, 32'd3);
        wr(5, 32'h0);
        rd_check("R11 masked write ignored", 5, 32'd1);
        wr(4, 32'h0);
        rd_check("R7 write zero keeps flag", 4, 32'd1);
        wr(4, 32'h1);
        rd_check("R7 write one clears flag", 4, 32'd0);
        check("R7 irq drops", 32'(irq[0]), 32'd0);
    endtask

    task automatic t_oneshot_masked;
        wr(7, 32'd2);
        wr(9, 32'h3);                 // en + oneshot, ie off
        rd_check("R2 timer1 loaded", 6, 32'd2);
        step(2);
        rd_check("R6 at zero no flag", 10, 32'd0);
        step(1);
        rd_check("R6 flag set", 10, 32'd1);
        rd_check("R8 masked zero with ie off", 11, 32'd0);
        check("R8 irq1 low with ie off", 32'(irq[1]), 32'd0);
        step(5);
        rd_check("R6 stays at zero", 6, 32'd0);
        wr(9, 32'h6);                 // ie + oneshot, disabled
        check("R8 irq1 follows ie", 32'(irq[1]), 32'd1);
        rd_check("R8 masked follows ie", 11, 32'd1);
        check("R2 timer0 unaffected", 32'(irq[0]), 32'd0);
        rd_check("R2 timer0 ctrl intact", 3, 32'h4);
        wr(10, 32'h1);
        check("R7 irq1 cleared", 32'(irq[1]), 32'd0);
    endtask

    task automatic t_background;
        wr(1, 32'd10);
        rd_check("R9 disabled store keeps count", 0, 32'd3);
        wr(3, 32'h1);
        rd_check("R4 enable loads", 0, 32'd10);
        wr(2, 32'd3);
        rd_check("R10 count undisturbed", 0, 32'd9);
        rd_check("R10 reload updated", 1, 32'd3);
        rd_check("R10 background stored", 2, 32'd3);
        step(9);
        rd_check("R10 old period runs out", 0, 32'd0);
        rd_check("R10 no flag yet", 4, 32'd0);
        step(1);
        rd_check("R10 new value at reload", 0, 32'd3);
        rd_check("R5 flag after background run", 4, 32'd1);
        wr(1, 32'd7);
        rd_check("R9 restart while enabled", 0, 32'd7);
    endtask

    task automatic t_ctrl_bits;
        wr(3, 32'hFFFF_FFF8);
        rd_check("R4 upper bits dropped", 3, 32'h0);
        wr(3, 32'hFFFF_FFFD);
        rd_check("R4 three bits stored", 3, 32'h5);
        wr(3, 32'h0);
    endtask

    task automatic t_unmapped;
        wr(12, 32'h55);
        wr(31, 32'hAA);
        rd_check("R3 read 12", 12, 32'h0);
        rd_check("R3 read 20", 20, 32'h0);
        rd_check("R3 read 31", 31, 32'h0);
        rd_check("R3 timer0 reload intact", 1, 32'd7);
        rd_check("R3 timer1 reload intact", 7, 32'd2);
        rd_check("R3 timer1 background intact", 8, 32'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_clear_and_ignore();
        t_oneshot_masked();
        t_background();
        t_ctrl_bits();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule